// File: doc/BRIEF.md
# Sequential Signed/Unsigned Restoring Divider

This block is a multi-cycle integer divider for a processor datapath. A one-cycle start pulse hands it a dividend, a divisor and a mode bit that selects signed or unsigned operation. The block works out one quotient bit per clock using restoring long division. When it finishes, the quotient sits in the `lo` register, the remainder sits in the `hi` register, and `done` pulses for one cycle.

Signed operands are first reduced to their magnitudes. An unsigned core divides the magnitudes, and a final cycle restores the signs with two's-complement negation (invert every bit, add one). The divider raises no flag and no trap. A zero divisor and the single signed overflow case both finish in the normal number of cycles and leave a defined result.

The operand width is a parameter. A second parameter selects how the negation is built: a plain adder or an explicit ripple chain.

Top module: `divr_seq_div`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `hi` and `lo` are all 0.
- R2: A `start` sampled high while `busy` is low is accepted. The block captures `dividend`, `divisor` and `is_signed` on that edge, and `busy` is high in the next cycle.
- R3: After an accepted start, the block spends one setup cycle, WIDTH iteration cycles and one sign-fix cycle. `done` rises WIDTH+2 clock edges after the accepting edge and stays high for exactly one cycle. `busy` is high through all of these cycles and is low whenever `done` is high.
- R4: With `is_signed` = 0, the operands are unsigned. `lo` = floor(dividend / divisor) and `hi` = dividend mod divisor. During the iterations the partial remainder stays below a nonzero divisor.
- R5: With `is_signed` = 1, the operands are two's complement. `lo` has the magnitude |dividend| / |divisor| rounded toward zero, and it is negative exactly when the operand signs differ. `hi` has the magnitude |dividend| mod |divisor| and takes the sign of the dividend.
- R6: A zero divisor raises no flag and keeps the normal latency. `hi` equals the dividend. In unsigned mode, and in signed mode with a non-negative dividend, `lo` is all ones. In signed mode with a negative dividend, `lo` is 1, because all ones is negated.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running division completes with its original operands and timing.
- R8: `hi` and `lo` change only on the edge that raises `done`. Between completions they hold their values whatever the inputs do.
- R9: Signed division of the most negative value by -1 gives `lo` = the most negative value and `hi` = 0, with no flag. In this case the magnitude 2^(WIDTH-1) is carried unsigned through the core.
- R10: The same operand bit patterns give different results in the two modes, as selected by `is_signed` (1 = signed, 0 = unsigned) at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when `hi`/`lo` are updated |
| hi | output | WIDTH | Remainder of the last completed division |
| lo | output | WIDTH | Quotient of the last completed division |

## Verification
The assertions check the control behaviour on every clock:
- a new start always makes the block busy;
- `done` is a single-cycle pulse that never coincides with `busy`;
- the busy period is exactly WIDTH+2 cycles;
- `hi`/`lo` are stable outside the sign-fix edge;
- the core's partial remainder stays below a nonzero divisor.

The arithmetic values themselves can only be shown by the bench's scenarios. These cover unsigned and signed quotients and remainders across every sign combination, the zero-divisor and most-negative-over-minus-one corners, the same bit patterns in both modes, and a start pulse arriving mid-operation.

// File: rtl/divr_pkg.sv
package divr_pkg;

   // Controller phases of one division
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_ITER = 2'd2,
      ST_FIX  = 2'd3
   } divr_state_e;

   // Operand signs recorded for the final correction
   typedef struct packed {
      logic a_neg;
      logic b_neg;
   } divr_sign_t;

endpackage

// File: rtl/divr_negate.sv
module divr_negate #(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] neg_o
);

   if (W < 2) begin : g_bad_width
      $error("divr_negate: W must be at least 2");
   end

   generate
      if (RIPPLE) begin : g_ripple
         // Invert then add one, with the increment carry rippled bit by bit
         logic [W-1:0] carry;
         assign carry[0] = 1'b1;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign neg_o[i] = (~val_i[i]) ^ carry[i];
            if (i < W-1) begin : g_carry
               assign carry[i+1] = (~val_i[i]) & carry[i];
            end
         end
      end else begin : g_plain
         assign neg_o = (~val_i) + {{(W-1){1'b0}}, 1'b1};
      end
   endgenerate

endmodule

// File: rtl/divr_sign_prep.sv
module divr_sign_prep
   import divr_pkg::*;
#(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         signed_i,
   output logic [W-1:0] a_mag_o,
   output logic [W-1:0] b_mag_o,
   output divr_sign_t   sign_o
);

   logic [W-1:0] a_neg_val;
   logic [W-1:0] b_neg_val;

   divr_negate #(.W(W), .RIPPLE(RIPPLE)) u_neg_a (.val_i(a_i), .neg_o(a_neg_val));
   divr_negate #(.W(W), .RIPPLE(RIPPLE)) u_neg_b (.val_i(b_i), .neg_o(b_neg_val));

   always_comb begin
      sign_o.a_neg = signed_i & a_i[W-1];
      sign_o.b_neg = signed_i & b_i[W-1];
      // The most negative value maps to 2^(W-1), read as unsigned
      a_mag_o = sign_o.a_neg ? a_neg_val : a_i;
      b_mag_o = sign_o.b_neg ? b_neg_val : b_i;
   end

endmodule

// File: rtl/divr_sign_fix.sv
module divr_sign_fix
   import divr_pkg::*;
#(
   parameter int W      = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] rem_i,
   input  divr_sign_t   sign_i,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   logic [W-1:0] quo_neg;
   logic [W-1:0] rem_neg;

   divr_negate #(.W(W), .RIPPLE(RIPPLE)) u_neg_q (.val_i(quo_i), .neg_o(quo_neg));
   divr_negate #(.W(W), .RIPPLE(RIPPLE)) u_neg_r (.val_i(rem_i), .neg_o(rem_neg));

   always_comb begin
      // Quotient is negative when signs differ; remainder follows the dividend
      quo_o = (sign_i.a_neg ^ sign_i.b_neg) ? quo_neg : quo_i;
      rem_o = sign_i.a_neg ? rem_neg : rem_i;
   end

endmodule

// File: rtl/divr_core.sv
module divr_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] a_mag_i,
   input  logic [W-1:0] b_mag_i,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   localparam int TW = W + 2;   // trial difference width, sign in MSB

   logic [W-1:0]  rem_q;        // partial remainder
   logic [W-1:0]  quo_q;        // dividend bits out at top, quotient bits in at bottom
   logic [W-1:0]  dsr_q;        // divisor magnitude
   logic [W:0]    shifted;
   logic [TW-1:0] trial;
   logic          below;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      trial   = {1'b0, shifted} - {2'b00, dsr_q};
      below   = trial[TW-1];    // subtraction went negative: restore
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dsr_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         quo_q <= a_mag_i;
         dsr_q <= b_mag_i;
      end else if (step_i) begin
         rem_q <= below ? shifted[W-1:0] : trial[W-1:0];
         quo_q <= {quo_q[W-2:0], ~below};
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q;

   AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && dsr_q != '0) |=> (rem_q < dsr_q))
      else $error("partial remainder reached divisor"); // R4

endmodule

// File: rtl/divr_seq_div.sv
module divr_seq_div
   import divr_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit NEG_RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo
);

   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);
   localparam int LAT_W = $clog2(WIDTH + 3);
   localparam int BUSY_CYCLES = WIDTH + 2;

   if (WIDTH < 2) begin : g_bad_width
      $error("divr_seq_div: WIDTH must be at least 2");
   end

   divr_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [WIDTH-1:0] op_a_q;
   logic [WIDTH-1:0] op_b_q;
   logic             sgn_q;
   logic             done_q;
   logic [WIDTH-1:0] hi_q;
   logic [WIDTH-1:0] lo_q;

   logic [WIDTH-1:0] a_mag;
   logic [WIDTH-1:0] b_mag;
   divr_sign_t       signs;
   logic [WIDTH-1:0] core_quo;
   logic [WIDTH-1:0] core_rem;
   logic [WIDTH-1:0] fix_quo;
   logic [WIDTH-1:0] fix_rem;

   divr_sign_prep #(.W(WIDTH), .RIPPLE(NEG_RIPPLE)) u_prep (
      .a_i      (op_a_q),
      .b_i      (op_b_q),
      .signed_i (sgn_q),
      .a_mag_o  (a_mag),
      .b_mag_o  (b_mag),
      .sign_o   (signs)
   );

   divr_core #(.W(WIDTH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (state_q == ST_PREP),
      .step_i  (state_q == ST_ITER),
      .a_mag_i (a_mag),
      .b_mag_i (b_mag),
      .quo_o   (core_quo),
      .rem_o   (core_rem)
   );

   divr_sign_fix #(.W(WIDTH), .RIPPLE(NEG_RIPPLE)) u_fix (
      .quo_i  (core_quo),
      .rem_i  (core_rem),
      .sign_i (signs),
      .quo_o  (fix_quo),
      .rem_o  (fix_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         op_a_q  <= '0;
         op_b_q  <= '0;
         sgn_q   <= 1'b0;
         done_q  <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  op_a_q  <= dividend;
                  op_b_q  <= divisor;
                  sgn_q   <= is_signed;
                  state_q <= ST_PREP;
               end
            end
            ST_PREP: begin
               cnt_q   <= '0;
               state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_STEP) state_q <= ST_FIX;
            end
            ST_FIX: begin
               hi_q    <= fix_rem;
               lo_q    <= fix_quo;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign hi   = hi_q;
   assign lo   = lo_q;

   // Length of the current busy stretch, kept for the latency check
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_q <= '0;
      else if (busy) lat_q <= lat_q + 1'b1;
      else           lat_q <= '0;
   end

   AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy) else $error("start not accepted"); // R2
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy)) else $error("done while busy"); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R3
   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LAT_W'(BUSY_CYCLES))) else $error("wrong busy length"); // R3
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_FIX) |=> ($stable(hi) && $stable(lo))) else $error("result moved"); // R8

endmodule

// File: tb/divr_seq_div_tb.sv
module divr_seq_div_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         is_signed = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy;
   logic         done;
   logic [W-1:0] hi;
   logic [W-1:0] lo;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   divr_seq_div #(.WIDTH(W), .NEG_RIPPLE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .hi(hi), .lo(lo)
   );

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Expected result from the requirements: magnitudes, unsigned divide, sign fix
   function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic sg,
                                   output logic [W-1:0] q, output logic [W-1:0] r);
      logic an, bn;
      logic [W-1:0] ma, mb, mq, mr;
      an = sg & a[W-1];
      bn = sg & b[W-1];
      ma = an ? (~a + 1'b1) : a;
      mb = bn ? (~b + 1'b1) : b;
      if (mb == '0) begin
         mq = '1;
         mr = ma;
      end else begin
         mq = ma / mb;
         mr = ma % mb;
      end
      q = (an ^ bn) ? (~mq + 1'b1) : mq;
      r = an ? (~mr + 1'b1) : mr;
   endfunction

   // One division; optional stray start pulse with other operands mid-run
   task automatic run_div(input string req, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic sg,
                          input bit stray);
      logic [W-1:0] eq, er;
      int lat;
      @(negedge clk);
      dividend = a; divisor = b; is_signed = sg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2", "busy after start", {{(W-1){1'b0}}, busy}, {{(W-1){1'b0}}, 1'b1});
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
         if (stray && lat == 10) begin
            dividend = ~a; divisor = 32'd3; is_signed = ~sg; start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      ref_div(a, b, sg, eq, er);
      check("R3", {req, " latency"}, W'(lat), W'(W + 3));
      check(req, "quotient lo", lo, eq);
      check(req, "remainder hi", hi, er);
   endtask

   task automatic t_reset;
      repeat (2) @(negedge clk);
      check("R1", "busy in reset", {{(W-1){1'b0}}, busy}, '0);
      check("R1", "done in reset", {{(W-1){1'b0}}, done}, '0);
      check("R1", "hi in reset", hi, '0);
      check("R1", "lo in reset", lo, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_unsigned;
      run_div("R4", 32'd100, 32'd7, 1'b0, 1'b0);
      run_div("R4", 32'hFFFF_FFFF, 32'h10, 1'b0, 1'b0);
      run_div("R4", 32'd3, 32'd10, 1'b0, 1'b0);
      run_div("R4", 32'hDEAD_BEEF, 32'h0001_2345, 1'b0, 1'b0);
   endtask

   task automatic t_signed;
      run_div("R5", -32'sd7, 32'sd2, 1'b1, 1'b0);
      run_div("R5", 32'sd7, -32'sd2, 1'b1, 1'b0);
      run_div("R5", -32'sd7, -32'sd2, 1'b1, 1'b0);
      run_div("R5", 32'sd1000, 32'sd33, 1'b1, 1'b0);
   endtask

   task automatic t_mode;
      run_div("R10", 32'hFFFF_FFF9, 32'd2, 1'b0, 1'b0);
      run_div("R10", 32'hFFFF_FFF9, 32'd2, 1'b1, 1'b0);
   endtask

   task automatic t_zero;
      run_div("R6", 32'd12345, 32'd0, 1'b0, 1'b0);
      run_div("R6", -32'sd9, 32'd0, 1'b1, 1'b0);
      run_div("R6", 32'd9, 32'd0, 1'b1, 1'b0);
   endtask

   task automatic t_overflow;
      run_div("R9", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
      run_div("R9", 32'h8000_0000, 32'd1, 1'b1, 1'b0);
   endtask

   task automatic t_start_busy;
      run_div("R7", 32'd5000, 32'd13, 1'b0, 1'b1);
   endtask

   task automatic t_hold;
      logic [W-1:0] keep_hi, keep_lo;
      run_div("R8", 32'd77, 32'd8, 1'b0, 1'b0);
      keep_hi = hi;
      keep_lo = lo;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         dividend = dividend + 32'd11;
         divisor  = divisor ^ 32'h5;
         is_signed = ~is_signed;
      end
      check("R8", "hi held", hi, keep_hi);
      check("R8", "lo held", lo, keep_lo);
      check("R8", "no done without start", {{(W-1){1'b0}}, done}, '0);
   endtask

   initial begin
      t_reset();
      t_unsigned();
      t_signed();
      t_mode();
      t_zero();
      t_overflow();
      t_start_busy();
      t_hold();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule